// File: doc/BRIEF.md
# Twelve-Bit Single-Cycle Processor Core

This block is a small processor that finishes one instruction on every clock edge. The program counter addresses an instruction store of 4096 words, each 25 bits wide. The store is read without a clock, so the current word is available at once. In the same cycle the word is decoded, two operands are picked from a bank of eight 12-bit registers, and the arithmetic unit computes a result. On the rising edge that result, the current program address or the instruction's immediate field is written back into a register. There is no data memory. The register values and the program counter are the block's outputs. A program is placed in the instruction store by writing the store array directly.

The core has no stream data path, so there is no valid/ready handshake and no back-pressure. Every pin is a plain control or status signal. Two instructions stop execution. The soft halt stops all register and flag updates while the program counter keeps counting and wraps. The hard halt freezes the program counter as well. A hard halt met while soft-halted still takes effect. Only the synchronous reset leaves either halt.

Top module: `cpu12_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter, all eight registers, the status flags and the halt state are all cleared to zero or to the running state.
- R2: An instruction word holds the opcode in bits 24..21, the destination index in 20..18, the first source index in 17..15, the second source index in 14..12 and an unsigned immediate in 11..0.
- R3: The opcodes compute the following values from A (the register selected by the first source index) and B (the register selected by the second source index). 0 computes ~A, 1 computes A&B, 2 computes A^B, 3 computes A|B, 4 computes A+B mod 4096 and 5 computes A-B mod 4096. 6 copies A. 10 gives 1 when A equals B and 0 otherwise. 12 shifts A left by one with a zero fill, keeping 12 bits. 13 shifts A right by one with a zero fill. The result is written to the destination register.
- R4: Opcode 8 writes the program address of that same instruction to the destination register. Opcode 9 writes the immediate field.
- R5: Register 0 is an ordinary register that can be written and read like the others. Any of the eight registers can be a source or a destination.
- R6: Opcodes 0–5, 10, 12 and 13 update a status word. Bit 0 is set when the result is zero. Bit 1 is the carry out of A+B, or of A+~B+1 for subtraction. Bit 2 is the signed two's-complement overflow. Bits 1 and 2 are forced to 0 for every opcode except 4 and 5. Opcode 7 writes the held status word, zero-extended, to the destination register. All other opcodes leave the status word unchanged.
- R7: While the core is running, the program counter advances by one modulo 4096 after each instruction. Opcode 11 loads the program counter with the value of register A and writes no register.
- R8: Opcode 14 writes nothing and enters the soft-halted state. In that state no register or status value changes, and the program counter still advances by one per cycle and wraps from 4095 to 0.
- R9: Opcode 15 writes nothing and freezes the program counter at its own address, whether the core is running or soft-halted. Nothing changes afterwards.
- R10: A synchronous reset leaves either halt state, and the program starts again at address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | 12 | Current program counter |
| regs_o | output | 96 | Register bank; register i in bits [12*i+11 : 12*i] |

## Verification
The bench builds the core with its default values: 12-bit data, eight registers and a 12-bit address, which gives the full 4096-word store. The full address space lets a soft halt run the program counter through its wrap from 4095 to 0 in about four thousand cycles. The bench then lets the counter reach a hard-halt word placed below the halt point. A store filled with pseudo-random words sweeps every non-halting opcode over all register indices, including jumps to arbitrary addresses. A bench model computed with integer arithmetic is compared against the core after every edge.

// File: rtl/cpu12_pkg.sv
package cpu12_pkg;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_NOT = 4'd0,  OP_AND = 4'd1,  OP_XOR = 4'd2,  OP_OR  = 4'd3,
    OP_ADD = 4'd4,  OP_SUB = 4'd5,  OP_MOV = 4'd6,  OP_MSW = 4'd7,
    OP_MPC = 4'd8,  OP_MVI = 4'd9,  OP_CMP = 4'd10, OP_JMP = 4'd11,
    OP_SLL = 4'd12, OP_SRL = 4'd13, OP_HLT = 4'd14, OP_HCF = 4'd15
  } op_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_FIRE = 2'd2
  } run_e;
endpackage

// File: rtl/cpu12_alu.sv
module cpu12_alu
  import cpu12_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         exec,
  input  op_e          op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] res
);
  localparam int SWW = 3;

  logic [W:0]     sum;
  logic           is_sub, is_arith, upd;
  logic           zf, cf, vf;
  logic [SWW-1:0] sw_q;

  assign is_sub   = (op == OP_SUB);
  assign is_arith = (op == OP_ADD) || is_sub;
  assign sum      = is_sub ? ({1'b0, opa} + {1'b0, ~opb} + (W+1)'(1))
                           : ({1'b0, opa} + {1'b0, opb});

  always_comb begin
    unique case (op)
      OP_NOT:  res = ~opa;
      OP_AND:  res = opa & opb;
      OP_XOR:  res = opa ^ opb;
      OP_OR:   res = opa | opb;
      OP_ADD,
      OP_SUB:  res = sum[W-1:0];
      OP_MOV:  res = opa;
      OP_MSW:  res = {{(W-SWW){1'b0}}, sw_q};
      OP_CMP:  res = (opa == opb) ? W'(1) : W'(0);
      OP_SLL:  res = {opa[W-2:0], 1'b0};
      OP_SRL:  res = {1'b0, opa[W-1:1]};
      default: res = '0;
    endcase
  end

  always_comb begin
    unique case (op)
      OP_NOT, OP_AND, OP_XOR, OP_OR, OP_ADD, OP_SUB,
      OP_CMP, OP_SLL, OP_SRL: upd = exec;
      default:                upd = 1'b0;
    endcase
  end

  assign zf = (res == '0);
  assign cf = is_arith & sum[W];
  assign vf = is_arith & (is_sub ? (opa[W-1] != opb[W-1]) : (opa[W-1] == opb[W-1]))
                       & (sum[W-1] != opa[W-1]);

  always_ff @(posedge clk) begin
    if (rst)      sw_q <= '0;
    else if (upd) sw_q <= {vf, cf, zf};
  end

  // R6
  flag_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (upd && !is_arith) |=> (sw_q[2:1] == 2'b00));
  // R6
  sw_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(sw_q));
  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (upd && res == '0) |=> sw_q[0]);
endmodule

// File: rtl/cpu12_seq.sv
module cpu12_seq
  import cpu12_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  op_e           op,
  input  logic [AW-1:0] tgt,
  output logic [AW-1:0] pc,
  output logic          exec
);
  run_e          st_q;
  logic [AW-1:0] pc_inc;

  assign pc_inc = pc + AW'(1);
  assign exec   = (st_q == ST_RUN) && (op != OP_HLT) && (op != OP_HCF);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc   <= '0;
      st_q <= ST_RUN;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (op == OP_HCF) st_q <= ST_FIRE;
          else begin
            if (op == OP_HLT) st_q <= ST_HALT;
            pc <= (op == OP_JMP) ? tgt : pc_inc;
          end
        end
        ST_HALT: begin
          if (op == OP_HCF) st_q <= ST_FIRE;
          else              pc   <= pc_inc;
        end
        default: ;
      endcase
    end
  end

  // R9
  fire_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_FIRE) |=> $stable(pc) && (st_q == ST_FIRE));
  // R8
  halt_count_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HALT && op != OP_HCF) |=> (pc == $past(pc) + AW'(1)));
  // R8
  halt_noexec_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_RUN) |-> !exec);
endmodule

// File: rtl/cpu12_rf.sv
module cpu12_rf #(
  parameter int W = 12,
  parameter int N = 8,
  localparam int AI = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AI-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AI-1:0] ra_a,
  input  logic [AI-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  output logic [N*W-1:0] flat
);
  logic [W-1:0] q [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                        q[g] <= '0;
      else if (we && wa == AI'(g))    q[g] <= wd;
    end
    assign flat[g*W +: W] = q[g];
  end

  assign rd_a = q[ra_a];
  assign rd_b = q[ra_b];

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> (flat == $past(flat)));
  // R5
  write_land_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (q[$past(wa)] == $past(wd)));
endmodule

// File: rtl/cpu12_core.sv
module cpu12_core
  import cpu12_pkg::*;
#(
  parameter int XLEN = 12,
  parameter int NREG = 8,
  parameter int AW   = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [AW-1:0]        pc_o,
  output logic [NREG*XLEN-1:0] regs_o
);
  localparam int RIW    = $clog2(NREG);
  localparam int IW     = OPW + 3*RIW + XLEN;
  localparam int DEPTH  = 2**AW;
  localparam int RS2_LO = XLEN;
  localparam int RS1_LO = RS2_LO + RIW;
  localparam int RD_LO  = RS1_LO + RIW;
  localparam int OP_LO  = RD_LO + RIW;

  logic [IW-1:0] imem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) imem[i] = '0;
  end

  logic [IW-1:0]   word;
  op_e             op;
  logic [RIW-1:0]  f_rd, f_rs1, f_rs2;
  logic [XLEN-1:0] f_imm, val_a, val_b, alu_res, wb;
  logic            exec, we;

  assign word  = imem[pc_o];
  assign op    = op_e'(word[OP_LO +: OPW]);
  assign f_rd  = word[RD_LO +: RIW];
  assign f_rs1 = word[RS1_LO +: RIW];
  assign f_rs2 = word[RS2_LO +: RIW];
  assign f_imm = word[XLEN-1:0];

  cpu12_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst(rst), .op(op), .tgt(val_a[AW-1:0]),
    .pc(pc_o), .exec(exec)
  );

  cpu12_rf #(.W(XLEN), .N(NREG)) u_rf (
    .clk(clk), .rst(rst), .we(we), .wa(f_rd), .wd(wb),
    .ra_a(f_rs1), .ra_b(f_rs2), .rd_a(val_a), .rd_b(val_b), .flat(regs_o)
  );

  cpu12_alu #(.W(XLEN)) u_alu (
    .clk(clk), .rst(rst), .exec(exec), .op(op),
    .opa(val_a), .opb(val_b), .res(alu_res)
  );

  assign we = exec && (op != OP_JMP);

  always_comb begin
    unique case (op)
      OP_MPC:  wb = XLEN'(pc_o);
      OP_MVI:  wb = f_imm;
      default: wb = alu_res;
    endcase
  end

  // R7
  jump_load_chk: assert property (@(posedge clk) disable iff (rst)
    (exec && op == OP_JMP) |=> (pc_o == $past(val_a[AW-1:0])));
  // R9
  fire_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_HCF) |-> !we);
  // R4
  mpc_value_chk: assert property (@(posedge clk) disable iff (rst)
    (we && op == OP_MPC) |-> (wb == XLEN'(pc_o)));
endmodule

// File: tb/sim_cpu12_core.sv
module sim_cpu12_core;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [11:0] pc_o;
  logic [95:0] regs_o;

  int total = 0;
  int bad   = 0;

  always #4ns clk = ~clk;

  cpu12_core u0 (.clk(clk), .rst(rst), .pc_o(pc_o), .regs_o(regs_o));

  logic [24:0] prog [4096];
  int m_r [8];
  int m_pc, m_sw, m_st;
  string tag;

  function automatic logic [24:0] enc(int op, int rd, int rs1, int rs2, int imm);
    return {op[3:0], rd[2:0], rs1[2:0], rs2[2:0], imm[11:0]};
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(tag, "pc", int'(pc_o), m_pc);
    for (int i = 0; i < 8; i++) chk(tag, $sformatf("x%0d", i), int'(regs_o[i*12 +: 12]), m_r[i]);
  endtask

  task automatic load(int n);
    for (int i = 0; i < n; i++) u0.imem[i] = prog[i];
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) m_r[i] = 0;
    m_pc = 0; m_sw = 0; m_st = 0;
    tag = "R1";
    compare_all();
  endtask

  function automatic int sgn(int v);
    return (v >= 2048) ? v - 4096 : v;
  endfunction

  task automatic model_step();
    logic [24:0] w;
    int op, rd, a, b, imm, r, s;
    bit wr, upd;
    w = prog[m_pc];
    op = int'(w[24:21]); rd = int'(w[20:18]);
    a = m_r[w[17:15]]; b = m_r[w[14:12]]; imm = int'(w[11:0]);
    if (m_st == 2) begin tag = "R9"; return; end
    if (op == 15) begin m_st = 2; tag = "R9"; return; end
    if (m_st == 1) begin m_pc = (m_pc + 1) % 4096; tag = "R8"; return; end
    if (op == 14) begin m_st = 1; m_pc = (m_pc + 1) % 4096; tag = "R8"; return; end
    wr = 1; upd = 1; r = 0; tag = "R3";
    case (op)
      0: r = 4095 - a;
      1: r = a & b;
      2: r = a ^ b;
      3: r = a | b;
      4: begin
           s = a + b; r = s % 4096;
           m_sw = ((sgn(a) + sgn(b) > 2047 || sgn(a) + sgn(b) < -2048) ? 4 : 0) + (s >= 4096 ? 2 : 0);
         end
      5: begin
           s = a + 4096 - b; r = s % 4096;
           m_sw = ((sgn(a) - sgn(b) > 2047 || sgn(a) - sgn(b) < -2048) ? 4 : 0) + (s >= 4096 ? 2 : 0);
         end
      6: begin r = a; upd = 0; end
      7: begin r = m_sw; upd = 0; tag = "R6"; end
      8: begin r = m_pc; upd = 0; tag = "R4"; end
      9: begin r = imm; upd = 0; tag = "R4"; end
      10: r = (a == b) ? 1 : 0;
      11: begin wr = 0; upd = 0; tag = "R7"; end
      12: r = (a * 2) % 4096;
      default: r = a / 2;
    endcase
    if (upd) begin
      if (op != 4 && op != 5) m_sw = 0;
      if (r == 0) m_sw = m_sw + 1;
    end
    if (wr) m_r[rd] = r;
    m_pc = (op == 11) ? a % 4096 : (m_pc + 1) % 4096;
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) begin
      model_step();
      @(posedge clk); @(negedge clk);
      compare_all();
    end
  endtask

  initial begin
    #(8ns * 190000);
    bad++; total++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    // Directed: x0 as a normal register, field decode, flags, MPC (R2 R4 R5 R6)
    for (int i = 0; i < 4096; i++) prog[i] = '0;
    prog[0] = enc(9, 0, 0, 0, 12'h800);
    prog[1] = enc(9, 1, 0, 0, 12'h800);
    prog[2] = enc(4, 2, 0, 1, 0);
    prog[3] = enc(6, 3, 2, 0, 0);
    prog[4] = enc(7, 4, 0, 0, 0);
    prog[5] = enc(8, 5, 0, 0, 0);
    prog[6] = enc(5, 6, 1, 0, 0);
    prog[7] = enc(7, 7, 0, 0, 0);
    load(4096);
    do_reset();
    run(8);
    chk("R5", "x0 written", int'(regs_o[11:0]), 2048);
    chk("R2", "add fields", int'(regs_o[24 +: 12]), 0);
    chk("R6", "add flags z|c|v", int'(regs_o[48 +: 12]), 7);
    chk("R4", "mpc address", int'(regs_o[60 +: 12]), 5);
    chk("R6", "sub equal flags", int'(regs_o[84 +: 12]), 3);

    // Random sweep of all non-halting opcodes (R3 R6 R7)
    lf = 16'hACE1;
    for (int i = 0; i < 4096; i++) begin
      logic [24:0] w;
      for (int j = 0; j < 25; j++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        w[j] = lf[0];
      end
      if (w[24:21] >= 4'd14) w[24:21] = 4'd9;
      prog[i] = w;
    end
    load(4096);
    do_reset();
    run(3000);

    // Soft halt, wrap, then hard halt below the halt point (R7 R8 R9)
    for (int i = 0; i < 4096; i++) prog[i] = '0;
    prog[0]  = enc(9, 1, 0, 0, 9);
    prog[1]  = enc(11, 0, 1, 0, 0);
    prog[5]  = enc(15, 0, 0, 0, 0);
    prog[9]  = enc(14, 0, 0, 0, 0);
    prog[10] = enc(9, 2, 0, 0, 77);
    load(4096);
    do_reset();
    run(4100);
    chk("R9", "frozen pc", int'(pc_o), 5);
    chk("R8", "x2 untouched", int'(regs_o[24 +: 12]), 0);

    // Hard halt from running, then reset recovers (R9 R10)
    for (int i = 0; i < 4096; i++) prog[i] = '0;
    prog[0] = enc(9, 3, 0, 0, 33);
    prog[1] = enc(15, 0, 0, 0, 0);
    prog[2] = enc(9, 4, 0, 0, 44);
    load(4096);
    do_reset();
    run(10);
    chk("R9", "pc held at fire", int'(pc_o), 1);
    do_reset();
    run(1);
    chk("R10", "runs after reset", int'(regs_o[36 +: 12]), 33);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule